// File: doc/BRIEF.md
# VLAN Membership Table Command Engine

This block holds a small table of VLAN entries. Each entry has a valid flag, a 12-bit VLAN ID and a 10-bit port member mask. Software never addresses the table directly. It first writes the member mask and valid flag of an entry into a data register. It then writes an opcode, a VLAN ID and an optional port number into a command register, with the start bit set.

The engine runs the command by visiting every table slot, one slot per clock. It clears the start bit when it has visited the last slot. A load that finds no matching VID and no free slot raises a full flag. A separate lookup port takes a VID and returns, one cycle later, a hit flag and the member mask of the matching entry. Forwarding logic can use this port while software manages the table through the host port.

The host port is a single-cycle register write with a combinational read, selected by one address bit (0 = command, 1 = data).

Top module: `vlan_cmd_engine`

## Requirements
- R1: After reset, the command register reads 0, the start/busy bit (bit 3) and the full bit (bit 4) are 0, the data register reads 0, and every lookup misses.
- R2: A command-register write with bit 3 set starts a command when no command is running. Bit 3 then reads 1 for exactly N_ENTRIES cycles. A command write with bit 3 clear only stores its fields.
- R3: Opcode 2 (load) with a new VID writes {data bit 11 as valid, command VID bits [27:16], data mask bits [9:0]} into the lowest-indexed slot whose valid flag is 0.
- R4: A load whose VID equals that of a valid entry overwrites that entry (the lowest-indexed such entry) instead of taking a free slot.
- R5: A load that finds no matching valid entry and no free slot sets bit 4 and leaves the table unchanged. Bit 4 clears when the next command starts.
- R6: Opcode 3 (purge) invalidates the valid entry whose VID matches. With no match, the table is unchanged.
- R7: Opcode 4 (remove port) clears bit P of the mask of every valid entry, where P is command bits [11:8]. A P of 10 or more changes nothing.
- R8: Opcode 1 (flush) invalidates every entry.
- R9: Writes to either register while a command is running are ignored.
- R10: The lookup port returns the hit flag and the member mask one cycle after the VID is applied. On a miss, the mask is 0.
- R11: Opcodes 0, 5, 6 and 7 leave the table unchanged but still hold bit 3 for N_ENTRIES cycles.
- R12: The command register reads back opcode [2:0], port [11:8], VID [27:16], priority [30:28] and priority enable [31] as written, with bits 7:5 and 15:12 reading 0. The data register reads back bits 9:0 and 11, with all other bits reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_wr | input | 1 | Host register write strobe |
| hst_sel | input | 1 | Register select: 0 = command, 1 = data |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Read data of the selected register (combinational) |
| lk_vid | input | 12 | VID to look up |
| lk_hit | output | 1 | Lookup found a valid entry (registered) |
| lk_mask | output | 10 | Member mask of the hit entry, 0 on a miss (registered) |

## Verification
A command accepted at clock edge k shows bit 3 set at the next falling edge. Bit 3 stays set until edge k+N_ENTRIES, and the table update is visible from that same edge. The bench counts falling edges while bit 3 is high and expects exactly N_ENTRIES. It compares the table only after bit 3 drops. A lookup VID applied at one falling edge is registered at the next rising edge. The hit flag and mask are therefore sampled at the following falling edge, against a reference table kept in the bench.

// File: rtl/vtab_pkg.sv
package vtab_pkg;
  localparam int VID_W  = 12;
  localparam int MASK_W = 10;
  localparam int PORT_W = 4;
  localparam int OP_W   = 3;
  localparam int PRIO_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_NOP       = 3'd0,
    OP_FLUSH     = 3'd1,
    OP_LOAD      = 3'd2,
    OP_PURGE     = 3'd3,
    OP_DROP_PORT = 3'd4
  } vt_op_e;

  typedef struct packed {
    logic              valid;
    logic [VID_W-1:0]  vid;
    logic [MASK_W-1:0] mask;
  } vt_entry_t;

  function automatic logic vid_hit(vt_entry_t e, logic [VID_W-1:0] v);
    return e.valid && (e.vid == v);
  endfunction

  // clear one member bit; a port number outside the mask leaves it alone
  function automatic logic [MASK_W-1:0] strip_port(logic [MASK_W-1:0] m,
                                                   logic [PORT_W-1:0] p);
    logic [MASK_W-1:0] r;
    r = m;
    for (int b = 0; b < MASK_W; b++)
      if (PORT_W'(b) == p) r[b] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/vtab_store.sv
module vtab_store
  import vtab_pkg::*;
#(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [IDX_W-1:0]     widx,
  input  vt_entry_t            wdata,
  output vt_entry_t [N-1:0]    entries
);
  for (genvar g = 0; g < N; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n)
        entries[g] <= '0;
      else if (we && widx == IDX_W'(g))
        entries[g] <= wdata;
    end
  end
endmodule

// File: rtl/vtab_lookup.sv
module vtab_lookup
  import vtab_pkg::*;
#(
  parameter int N = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  vt_entry_t [N-1:0] entries,
  input  logic [VID_W-1:0]  key,
  output logic              hit,
  output logic [MASK_W-1:0] mask
);
  logic              hit_c;
  logic [MASK_W-1:0] mask_c;

  // lowest index wins: scan downward so the last assignment is the lowest
  always_comb begin
    hit_c  = 1'b0;
    mask_c = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vid_hit(entries[i], key)) begin
        hit_c  = 1'b1;
        mask_c = entries[i].mask;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit  <= 1'b0;
      mask <= '0;
    end else begin
      hit  <= hit_c;
      mask <= mask_c;
    end
  end
endmodule

// File: rtl/vtab_seq.sv
module vtab_seq
  import vtab_pkg::*;
#(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OP_W-1:0]   op,
  input  logic [VID_W-1:0]  vid,
  input  logic [PORT_W-1:0] port,
  input  vt_entry_t         ld_entry,
  input  vt_entry_t [N-1:0] entries,
  output logic              busy,
  output logic              done,
  output logic              full_set,
  output logic              we,
  output logic [IDX_W-1:0]  widx,
  output vt_entry_t         wdata
);
  logic [IDX_W-1:0] idx, hidx, fidx;
  logic             fh, ff;
  vt_entry_t        cur;
  logic             hit_now, free_now, last;

  assign cur      = entries[idx];
  assign hit_now  = vid_hit(cur, vid);
  assign free_now = !cur.valid;
  assign last     = (idx == IDX_W'(N - 1));
  assign done     = busy && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      fh   <= 1'b0;
      ff   <= 1'b0;
      hidx <= '0;
      fidx <= '0;
    end else if (start) begin
      busy <= 1'b1;
      idx  <= '0;
      fh   <= 1'b0;
      ff   <= 1'b0;
    end else if (busy) begin
      if (hit_now && !fh) begin
        fh   <= 1'b1;
        hidx <= idx;
      end
      if (free_now && !ff) begin
        ff   <= 1'b1;
        fidx <= idx;
      end
      if (last) busy <= 1'b0;
      else      idx  <= idx + 1'b1;
    end
  end

  always_comb begin
    we       = 1'b0;
    widx     = idx;
    wdata    = cur;
    full_set = 1'b0;
    if (busy) begin
      case (vt_op_e'(op))
        OP_FLUSH: begin
          we    = 1'b1;
          wdata = '0;
        end
        OP_PURGE: begin
          if (hit_now) begin
            we          = 1'b1;
            wdata.valid = 1'b0;
          end
        end
        OP_DROP_PORT: begin
          if (cur.valid) begin
            we         = 1'b1;
            wdata.mask = strip_port(cur.mask, port);
          end
        end
        OP_LOAD: begin
          if (last) begin
            wdata = ld_entry;
            if (fh) begin
              we   = 1'b1;
              widx = hidx;
            end else if (hit_now) begin
              we = 1'b1;
            end else if (ff) begin
              we   = 1'b1;
              widx = fidx;
            end else if (free_now) begin
              we = 1'b1;
            end else begin
              full_set = 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/vlan_cmd_engine.sv
module vlan_cmd_engine
  import vtab_pkg::*;
#(
  parameter int N_ENTRIES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_wr,
  input  logic              hst_sel,
  input  logic [31:0]       hst_wdata,
  output logic [31:0]       hst_rdata,
  input  logic [VID_W-1:0]  lk_vid,
  output logic              lk_hit,
  output logic [MASK_W-1:0] lk_mask
);
  localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;

  logic [OP_W-1:0]   c_op;
  logic [PORT_W-1:0] c_port;
  logic [VID_W-1:0]  c_vid;
  logic [PRIO_W-1:0] c_prio;
  logic              c_pen;
  logic [MASK_W-1:0] d_mask;
  logic              d_valid;
  logic              full_q;

  logic              busy, evt_done, evt_full_set;
  logic              st_we;
  logic [IDX_W-1:0]  st_widx;
  vt_entry_t         st_wdata;
  vt_entry_t [N_ENTRIES-1:0] entries;
  vt_entry_t         ld_entry;

  // named events for the checker
  logic evt_cmd_wr, evt_data_wr, evt_start, evt_cmd_drop, evt_data_drop;
  logic [OP_W+PORT_W+VID_W+PRIO_W:0] cmd_fields;

  assign evt_cmd_wr    = hst_wr && !hst_sel;
  assign evt_data_wr   = hst_wr && hst_sel;
  assign evt_start     = evt_cmd_wr && !busy && hst_wdata[3];
  assign evt_cmd_drop  = evt_cmd_wr && busy;
  assign evt_data_drop = evt_data_wr && busy;
  assign cmd_fields    = {c_pen, c_prio, c_vid, c_port, c_op};

  logic unused_wbits;
  assign unused_wbits = ^{hst_wdata[7:4], hst_wdata[15:12]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_op    <= '0;
      c_port  <= '0;
      c_vid   <= '0;
      c_prio  <= '0;
      c_pen   <= 1'b0;
      d_mask  <= '0;
      d_valid <= 1'b0;
      full_q  <= 1'b0;
    end else begin
      if (evt_cmd_wr && !busy) begin
        c_op   <= hst_wdata[2:0];
        c_port <= hst_wdata[11:8];
        c_vid  <= hst_wdata[27:16];
        c_prio <= hst_wdata[30:28];
        c_pen  <= hst_wdata[31];
      end
      if (evt_data_wr && !busy) begin
        d_mask  <= hst_wdata[9:0];
        d_valid <= hst_wdata[11];
      end
      if (evt_start)         full_q <= 1'b0;
      else if (evt_full_set) full_q <= 1'b1;
    end
  end

  always_comb begin
    ld_entry.valid = d_valid;
    ld_entry.vid   = c_vid;
    ld_entry.mask  = d_mask;
  end

  assign hst_rdata = hst_sel
    ? {20'h0, d_valid, 1'b0, d_mask}
    : {c_pen, c_prio, c_vid, 4'h0, c_port, 3'b000, full_q, busy, c_op};

  vtab_seq #(.N(N_ENTRIES), .IDX_W(IDX_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (evt_start),
    .op       (c_op),
    .vid      (c_vid),
    .port     (c_port),
    .ld_entry (ld_entry),
    .entries  (entries),
    .busy     (busy),
    .done     (evt_done),
    .full_set (evt_full_set),
    .we       (st_we),
    .widx     (st_widx),
    .wdata    (st_wdata)
  );

  vtab_store #(.N(N_ENTRIES), .IDX_W(IDX_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (st_we),
    .widx    (st_widx),
    .wdata   (st_wdata),
    .entries (entries)
  );

  vtab_lookup #(.N(N_ENTRIES)) u_lookup (
    .clk     (clk),
    .rst_n   (rst_n),
    .entries (entries),
    .key     (lk_vid),
    .hit     (lk_hit),
    .mask    (lk_mask)
  );
endmodule

// File: rtl/vtab_checker.sv
module vtab_checker
  import vtab_pkg::*;
#(
  parameter int N = 16
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              busy,
  input logic                              evt_start,
  input logic                              evt_done,
  input logic                              evt_full_set,
  input logic                              evt_cmd_drop,
  input logic                              evt_data_drop,
  input logic [OP_W+PORT_W+VID_W+PRIO_W:0] cmd_fields,
  input logic [31:0]                       hst_rdata,
  input logic                              hst_sel,
  input logic                              lk_hit,
  input logic [MASK_W-1:0]                 lk_mask
);
  logic [15:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)         busy_cnt <= '0;
    else if (evt_start) busy_cnt <= '0;
    else if (busy)      busy_cnt <= busy_cnt + 1'b1;
  end

  // R2
  start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_start |=> busy);

  // R2
  done_clears_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |=> !busy);

  // R2
  scan_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |-> (busy_cnt == 16'(N - 1)));

  // R9
  cmd_drop_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_cmd_drop |=> $stable(cmd_fields));

  // R9
  data_drop_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_data_drop && hst_sel) |=> (hst_sel -> $stable(hst_rdata)));

  // R5
  full_only_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_full_set |-> (evt_done && cmd_fields[OP_W-1:0] == OP_LOAD));

  // R10
  miss_zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_mask == '0));
endmodule

bind vlan_cmd_engine vtab_checker #(.N(N_ENTRIES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .evt_start     (evt_start),
  .evt_done      (evt_done),
  .evt_full_set  (evt_full_set),
  .evt_cmd_drop  (evt_cmd_drop),
  .evt_data_drop (evt_data_drop),
  .cmd_fields    (cmd_fields),
  .hst_rdata     (hst_rdata),
  .hst_sel       (hst_sel),
  .lk_hit        (lk_hit),
  .lk_mask       (lk_mask)
);

// File: tb/tb_vlan_cmd_engine.sv
`timescale 1ns/1ps
module tb_vlan_cmd_engine;
  localparam int N = 16;
  localparam int NPOOL = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hst_wr = 1'b0;
  logic        hst_sel = 1'b0;
  logic [31:0] hst_wdata = '0;
  logic [31:0] hst_rdata;
  logic [11:0] lk_vid = '0;
  logic        lk_hit;
  logic [9:0]  lk_mask;

  int checks = 0;
  int errors = 0;

  // reference table
  bit          mv   [N];
  logic [11:0] mvid [N];
  logic [9:0]  mmask[N];
  bit          mfull;
  logic [9:0]  cur_dmask;
  bit          cur_dvalid;

  always #4 clk = ~clk;

  vlan_cmd_engine #(.N_ENTRIES(N)) dut (
    .clk(clk), .rst_n(rst_n), .hst_wr(hst_wr), .hst_sel(hst_sel),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
    .lk_vid(lk_vid), .lk_hit(lk_hit), .lk_mask(lk_mask)
  );

  function automatic logic [11:0] pool_vid(int i);
    return 12'((100 + i * 37) % 4096);
  endfunction

  function automatic logic [31:0] mk_cmd(logic [2:0] op, logic [11:0] vid,
                                         logic [3:0] port, bit go,
                                         logic [2:0] prio, bit pen);
    return {pen, prio, vid, 4'h0, port, 3'b000, 1'b0, go, op};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(bit sel, logic [31:0] d);
    @(negedge clk);
    hst_wr = 1'b1; hst_sel = sel; hst_wdata = d;
    @(negedge clk);
    hst_wr = 1'b0; hst_sel = 1'b0;
    if (sel) begin
      cur_dmask  = d[9:0];
      cur_dvalid = d[11];
    end
  endtask

  task automatic rd(bit sel, output logic [31:0] v);
    hst_sel = sel;
    #1;
    v = hst_rdata;
    hst_sel = 1'b0;
    #1;
  endtask

  task automatic wait_idle(output int cnt);
    cnt = 0;
    hst_sel = 1'b0;
    #1;
    while (hst_rdata[3] && cnt < 200) begin
      @(negedge clk);
      #1;
      cnt++;
    end
  endtask

  task automatic model_cmd(logic [2:0] op, logic [11:0] vid, logic [3:0] port);
    int h, f;
    mfull = 1'b0;
    case (op)
      3'd1: for (int i = 0; i < N; i++) mv[i] = 1'b0;
      3'd2: begin
        h = -1; f = -1;
        for (int i = N - 1; i >= 0; i--) begin
          if (mv[i] && mvid[i] == vid) h = i;
          if (!mv[i]) f = i;
        end
        if (h < 0) h = f;
        if (h < 0) mfull = 1'b1;
        else begin
          mv[h] = cur_dvalid; mvid[h] = vid; mmask[h] = cur_dmask;
        end
      end
      3'd3: for (int i = 0; i < N; i++)
              if (mv[i] && mvid[i] == vid) mv[i] = 1'b0;
      3'd4: if (port < 10)
              for (int i = 0; i < N; i++)
                if (mv[i]) mmask[i][port] = 1'b0;
      default: ;
    endcase
  endtask

  task automatic lookup_chk(logic [11:0] vid, string req);
    bit eh; logic [9:0] em;
    eh = 1'b0; em = '0;
    for (int i = N - 1; i >= 0; i--)
      if (mv[i] && mvid[i] == vid) begin eh = 1'b1; em = mmask[i]; end
    @(negedge clk);
    lk_vid = vid;
    @(negedge clk);
    chk(lk_hit == eh && lk_mask == em, req, {21'h0, lk_hit, lk_mask}, {21'h0, eh, em});
  endtask

  task automatic run_cmd(logic [2:0] op, logic [11:0] vid, logic [3:0] port,
                         string req);
    int cnt; logic [31:0] v;
    wr(1'b0, mk_cmd(op, vid, port, 1'b1, 3'd5, 1'b1));
    rd(1'b0, v);
    chk(v[3] == 1'b1 && v[4] == 1'b0, "R2/R5 start", v, 32'h8);
    wait_idle(cnt);
    chk(cnt == N, {req, " R2 cycles"}, cnt, N);
    model_cmd(op, vid, port);
    rd(1'b0, v);
    chk(v == {1'b1, 3'd5, vid, 4'h0, port, 3'b000, mfull, 1'b0, op},
        {req, " R12 readback"}, v,
        {1'b1, 3'd5, vid, 4'h0, port, 3'b000, mfull, 1'b0, op});
  endtask

  task automatic check_pool(string req);
    for (int i = 0; i < NPOOL; i++) lookup_chk(pool_vid(i), req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int cnt;
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) begin mv[i] = 0; mvid[i] = '0; mmask[i] = '0; end
    mfull = 0; cur_dmask = '0; cur_dvalid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(1'b0, v); chk(v == 32'h0, "R1 cmd reg", v, 0);
    rd(1'b1, v); chk(v == 32'h0, "R1 data reg", v, 0);
    lookup_chk(pool_vid(0), "R1 lookup miss");

    // R12 readback without start (R2: no start)
    wr(1'b0, mk_cmd(3'd3, 12'hABC, 4'd7, 1'b0, 3'd6, 1'b1));
    rd(1'b0, v);
    chk(v == mk_cmd(3'd3, 12'hABC, 4'd7, 1'b0, 3'd6, 1'b1), "R12 R2 no-start readback", v,
        mk_cmd(3'd3, 12'hABC, 4'd7, 1'b0, 3'd6, 1'b1));
    wr(1'b1, 32'hFFFF_FFFF);
    rd(1'b1, v); chk(v == 32'h0000_0BFF, "R12 data readback", v, 32'hBFF);

    // R3 fill table with new VIDs
    for (int i = 0; i < N; i++) begin
      wr(1'b1, {20'h0, 1'b1, 1'b0, 10'(i * 3 + 1)});
      run_cmd(3'd2, pool_vid(i), 4'd0, "R3");
    end
    check_pool("R3 fill");
    // R5 full
    wr(1'b1, {20'h0, 1'b1, 1'b0, 10'h3FF});
    run_cmd(3'd2, pool_vid(20), 4'd0, "R5");
    rd(1'b0, v); chk(v[4] == 1'b1, "R5 full bit", v, 32'h10);
    lookup_chk(pool_vid(20), "R5 unchanged");
    // R4 overwrite while full
    wr(1'b1, {20'h0, 1'b1, 1'b0, 10'h2AA});
    run_cmd(3'd2, pool_vid(5), 4'd0, "R4");
    rd(1'b0, v); chk(v[4] == 1'b0, "R5 full cleared", v, 0);
    lookup_chk(pool_vid(5), "R4 overwrite");
    // R6 purge and purge miss
    run_cmd(3'd3, pool_vid(7), 4'd0, "R6");
    run_cmd(3'd3, 12'hFFF, 4'd0, "R6 miss");
    check_pool("R6");
    // R3 reuse freed slot
    wr(1'b1, {20'h0, 1'b1, 1'b0, 10'h155});
    run_cmd(3'd2, pool_vid(21), 4'd0, "R3 reuse");
    lookup_chk(pool_vid(21), "R3 reuse");
    // R7 remove port and out-of-range port
    run_cmd(3'd4, 12'h0, 4'd1, "R7");
    run_cmd(3'd4, 12'h0, 4'd12, "R7 range");
    check_pool("R7");
    // R11 reserved opcodes
    run_cmd(3'd6, pool_vid(2), 4'd0, "R11");
    run_cmd(3'd0, pool_vid(3), 4'd0, "R11 nop");
    check_pool("R11");
    // R9 writes while busy ignored
    wr(1'b1, {20'h0, 1'b1, 1'b0, 10'h0F0});
    wr(1'b0, mk_cmd(3'd2, pool_vid(22), 4'd2, 1'b1, 3'd1, 1'b0));
    wr(1'b0, mk_cmd(3'd1, 12'h123, 4'd9, 1'b1, 3'd7, 1'b1));
    wr(1'b1, {20'h0, 1'b1, 1'b0, 10'h00F});
    cur_dmask = 10'h0F0;
    wait_idle(cnt);
    model_cmd(3'd2, pool_vid(22), 4'd2);
    rd(1'b0, v);
    chk(v == {1'b0, 3'd1, pool_vid(22), 4'h0, 4'd2, 3'b000, mfull, 1'b0, 3'd2}, "R9 cmd kept", v,
        {1'b0, 3'd1, pool_vid(22), 4'h0, 4'd2, 3'b000, mfull, 1'b0, 3'd2});
    rd(1'b1, v); chk(v == 32'h0000_08F0, "R9 data kept", v, 32'h8F0);
    check_pool("R9");
    // R8 flush
    run_cmd(3'd1, 12'h0, 4'd0, "R8");
    check_pool("R8 R10 miss");

    // random mix
    for (int n = 0; n < 120; n++) begin
      int r; logic [2:0] op;
      r = int'($urandom_range(0, 99));
      if (r < 50) op = 3'd2;
      else if (r < 70) op = 3'd3;
      else if (r < 82) op = 3'd4;
      else if (r < 86) op = 3'd1;
      else op = 3'($urandom_range(5, 7));
      if (op == 3'd2)
        wr(1'b1, {20'h0, ($urandom_range(0, 7) != 0), 1'b0, 10'($urandom)});
      run_cmd(op, pool_vid(int'($urandom_range(0, NPOOL - 1))),
              4'($urandom_range(0, 11)), "R3/R4/R6/R7 random");
      for (int k = 0; k < 4; k++)
        lookup_chk(pool_vid(int'($urandom_range(0, NPOOL - 1))), "R10 random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule